// File: doc/BRIEF.md
# Sequential Read Port for a Content-Addressable Table

This block is the control-side read path of a content-addressable lookup table. Software first writes a start address into the low bits of I/O word 0 and issues a pointer-load command. Each read command after that copies the table entry at the pointer into four 16-bit I/O words, then moves the pointer to the next entry. A run of reads therefore returns neighbouring entries in order, and software never has to rewrite the address.

Both commands are valid only while the entry-update queue reports empty. If either command arrives while updates are still pending, it is refused. A refused command changes neither the pointer nor the I/O words. It loads a fixed error code, sets a sticky error flag, and raises the interrupt line if that source is enabled. A plain write port preloads the table contents. The matching and insertion logic that normally fills the table sit elsewhere.

Top module: `cam_fastread_port`

## Requirements
- R1: After synchronous reset, `fast_ptr`, `io_data`, `err_code`, `flags` bit 7, `done` and `irq` are all zero.
- R2: A host write with `ioreg_wr_en` loads `ioreg_wr_data` into I/O word `ioreg_wr_sel` (word k occupies `io_data[16k+15:16k]`). The new value is visible after the next clock edge.
- R3: A pointer-load command (`cmd_op` = 2'b01) with `queue_empty` high sets `fast_ptr` to bits 13:0 of I/O word 0.
- R4: A read command (`cmd_op` = 2'b10) with `queue_empty` high copies the table entry at `fast_ptr` into `io_data`. Entry bit 63 lands in word 3 bit 15 and entry bit 0 in word 0 bit 0. `done` is high for exactly the one cycle that follows the command.
- R5: After each accepted read, `fast_ptr` advances by one and wraps from DEPTH-1 to 0.
- R6: A read with `fast_ptr` at or beyond DEPTH returns an all-zero entry and leaves `fast_ptr` at 0.
- R7: A read command with `queue_empty` low sets `err_code` to 16'hFFFC and sets `flags` bit 7. `fast_ptr` and `io_data` keep their values and `done` stays low.
- R8: A pointer-load command with `queue_empty` low sets `err_code` to 16'hFFFD and sets `flags` bit 7. `fast_ptr` keeps its value.
- R9: `flags` bit 4 follows `queue_empty` in the same cycle.
- R10: Writing a 1 through `flag_clr_wr`/`flag_clr_data` clears the matching flag bit, and writing 0 leaves it unchanged. A new error in the same cycle as a clear leaves the bit set.
- R11: `irq` is high exactly when a pending flag bit has its enable bit set. The enable bits are written through `irq_en_wr`/`irq_en_data`, and the error source uses enable bit 7.
- R12: `cmd_op` values 2'b00 and 2'b11 have no effect, whatever `queue_empty` is: no error and no change to the pointer.
- R13: A write with `tbl_wr_en` stores `tbl_wr_data` at entry `tbl_wr_addr`, and a later read returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 2 | Command opcode: 01 load pointer, 10 read |
| queue_empty | input | 1 | Entry-update queue is empty |
| ioreg_wr_en | input | 1 | Host write to an I/O word |
| ioreg_wr_sel | input | 2 | Index of the I/O word to write |
| ioreg_wr_data | input | 16 | Data for the I/O word |
| tbl_wr_en | input | 1 | Table preload strobe |
| tbl_wr_addr | input | ADDR_W | Table preload address |
| tbl_wr_data | input | 64 | Table preload entry |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_data | input | 16 | Write-one-to-clear mask |
| irq_en_wr | input | 1 | Interrupt-enable write strobe |
| irq_en_data | input | 16 | Interrupt-enable value |
| io_data | output | 64 | I/O words 3..0, word 3 in the top bits |
| fast_ptr | output | 14 | Sequential read pointer |
| flags | output | 16 | Flag word: bit 4 queue empty, bit 7 error |
| err_code | output | 16 | Code of the last refused command |
| done | output | 1 | Pulse after an accepted read |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle. A `done` pulse must follow an accepted read. A refused command must load its code and set the flag while the pointer holds. The pointer must step with wrap, or take word 0 on a pointer load. The error flag may fall only on a clear write, `irq` needs a pending flag, and unused opcodes must stay quiet. Only the bench scenarios can show the actual entry data and its word order, and the zero entry returned past the table end. The same holds for the clear-versus-set collision, for a preload followed by a read, and for the interrupt following enable writes.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int WORD_W  = 16;
    localparam int NUM_IO  = 4;
    localparam int ENTRY_W = WORD_W * NUM_IO;
    localparam int PTR_W   = 14;
    localparam int SEL_W   = $clog2(NUM_IO);

    localparam int FLAG_QEMPTY = 4;
    localparam int FLAG_ERR    = 7;

    localparam logic [WORD_W-1:0] ERR_READ_BUSY = 16'hFFFC;
    localparam logic [WORD_W-1:0] ERR_LOAD_BUSY = 16'hFFFD;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_LOAD = 2'b01,
        OP_READ = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef struct packed {
        logic              do_load;
        logic              do_read;
        logic              refuse;
        logic [WORD_W-1:0] code;
    } cmd_dec_t;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input int unsigned depth);
        if (32'(p) + 32'd1 >= depth)
            return '0;
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/fr_table.sv
module fr_table
    import fr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_ptr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] rows [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst)
                    rows[g] <= '0;
                else if (wr_en && (32'(wr_addr) == g))
                    rows[g] <= wr_data;
            end
        end
    endgenerate

    logic in_range;
    assign in_range = (32'(rd_ptr) < DEPTH);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (in_range && (32'(rd_ptr) == i))
                rd_data = rows[i];
        end
    end

endmodule

// File: rtl/fr_decode.sv
module fr_decode
    import fr_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       queue_empty,
    output cmd_dec_t   dec
);

    op_e op;
    assign op = op_e'(cmd_op);

    always_comb begin
        dec = '0;
        if (cmd_valid) begin
            unique case (op)
                OP_LOAD: begin
                    if (queue_empty) begin
                        dec.do_load = 1'b1;
                    end else begin
                        dec.refuse = 1'b1;
                        dec.code   = ERR_LOAD_BUSY;
                    end
                end
                OP_READ: begin
                    if (queue_empty) begin
                        dec.do_read = 1'b1;
                    end else begin
                        dec.refuse = 1'b1;
                        dec.code   = ERR_READ_BUSY;
                    end
                end
                default: dec = '0;
            endcase
        end
    end

endmodule

// File: rtl/fr_status.sv
module fr_status
    import fr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              queue_empty,
    input  logic              err_set,
    input  logic [WORD_W-1:0] err_code_in,
    input  logic              clr_wr,
    input  logic [WORD_W-1:0] clr_data,
    input  logic              ie_wr,
    input  logic [WORD_W-1:0] ie_data,
    output logic [WORD_W-1:0] flags,
    output logic [WORD_W-1:0] err_code,
    output logic              irq
);

    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] pend_q;
    logic [WORD_W-1:0] ie_q;
    logic [WORD_W-1:0] live_vec;

    assign set_vec  = WORD_W'(err_set) << FLAG_ERR;
    assign live_vec = WORD_W'(queue_empty) << FLAG_QEMPTY;

    genvar b;
    generate
        for (b = 0; b < WORD_W; b++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    pend_q[b] <= 1'b0;
                else if (set_vec[b])
                    pend_q[b] <= 1'b1;
                else if (clr_wr && clr_data[b])
                    pend_q[b] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q     <= '0;
            err_code <= '0;
        end else begin
            if (ie_wr)
                ie_q <= ie_data;
            if (err_set)
                err_code <= err_code_in;
        end
    end

    assign flags = pend_q | live_vec;
    assign irq   = |(pend_q & ie_q);

endmodule

// File: rtl/cam_fastread_port.sv
module cam_fastread_port
    import fr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic               queue_empty,
    input  logic               ioreg_wr_en,
    input  logic [1:0]         ioreg_wr_sel,
    input  logic [15:0]        ioreg_wr_data,
    input  logic               tbl_wr_en,
    input  logic [ADDR_W-1:0]  tbl_wr_addr,
    input  logic [63:0]        tbl_wr_data,
    input  logic               flag_clr_wr,
    input  logic [15:0]        flag_clr_data,
    input  logic               irq_en_wr,
    input  logic [15:0]        irq_en_data,
    output logic [63:0]        io_data,
    output logic [13:0]        fast_ptr,
    output logic [15:0]        flags,
    output logic [15:0]        err_code,
    output logic               done,
    output logic               irq
);

    cmd_dec_t           dec;
    logic [ENTRY_W-1:0] entry;
    logic [WORD_W-1:0]  io_q [NUM_IO];
    logic [PTR_W-1:0]   ptr_q;
    logic               done_q;

    fr_decode u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .queue_empty (queue_empty),
        .dec         (dec)
    );

    fr_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_ptr  (ptr_q),
        .rd_data (entry)
    );

    fr_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .queue_empty (queue_empty),
        .err_set     (dec.refuse),
        .err_code_in (dec.code),
        .clr_wr      (flag_clr_wr),
        .clr_data    (flag_clr_data),
        .ie_wr       (irq_en_wr),
        .ie_data     (irq_en_data),
        .flags       (flags),
        .err_code    (err_code),
        .irq         (irq)
    );

    genvar w;
    generate
        for (w = 0; w < NUM_IO; w++) begin : g_io
            always_ff @(posedge clk) begin
                if (rst)
                    io_q[w] <= '0;
                else if (dec.do_read)
                    io_q[w] <= entry[w*WORD_W +: WORD_W];
                else if (ioreg_wr_en && (32'(ioreg_wr_sel) == w))
                    io_q[w] <= ioreg_wr_data;
            end
            assign io_data[w*WORD_W +: WORD_W] = io_q[w];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= dec.do_read;
            if (dec.do_load)
                ptr_q <= io_q[0][PTR_W-1:0];
            else if (dec.do_read)
                ptr_q <= step_ptr(ptr_q, DEPTH);
        end
    end

    assign fast_ptr = ptr_q;
    assign done     = done_q;

endmodule

// File: rtl/fr_port_chk.sv
module fr_port_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        queue_empty,
    input logic        ioreg_wr_en,
    input logic        flag_clr_wr,
    input logic [15:0] flag_clr_data,
    input logic [63:0] io_data,
    input logic [13:0] fast_ptr,
    input logic [15:0] flags,
    input logic [15:0] err_code,
    input logic        done,
    input logic        irq
);

    logic acc_read, acc_load, ref_read, ref_load, quiet_op;
    assign acc_read = cmd_valid && cmd_op == 2'b10 && queue_empty;
    assign acc_load = cmd_valid && cmd_op == 2'b01 && queue_empty;
    assign ref_read = cmd_valid && cmd_op == 2'b10 && !queue_empty;
    assign ref_load = cmd_valid && cmd_op == 2'b01 && !queue_empty;
    assign quiet_op = cmd_valid && (cmd_op == 2'b00 || cmd_op == 2'b11);

    // R4
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(acc_read));

    // R7
    refused_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_read && !ioreg_wr_en) |=>
            (flags[7] && err_code == 16'hFFFC && $stable(io_data) && $stable(fast_ptr) && !done));

    // R8
    refused_load_chk: assert property (@(posedge clk) disable iff (rst)
        ref_load |=> (flags[7] && err_code == 16'hFFFD && $stable(fast_ptr)));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        acc_read |=> (32'(fast_ptr) ==
            ((32'($past(fast_ptr)) + 32'd1 >= 32'(DEPTH)) ? 32'd0 : 32'($past(fast_ptr)) + 32'd1)));

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        acc_load |=> (fast_ptr == $past(io_data[13:0])));

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[7]) |-> $past(flag_clr_wr && flag_clr_data[7]));

    // R11
    irq_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> flags[7]);

    // R12
    quiet_op_chk: assert property (@(posedge clk) disable iff (rst)
        (quiet_op && !flags[7]) |=> (!flags[7] && $stable(fast_ptr)));

endmodule

bind cam_fastread_port fr_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .queue_empty   (queue_empty),
    .ioreg_wr_en   (ioreg_wr_en),
    .flag_clr_wr   (flag_clr_wr),
    .flag_clr_data (flag_clr_data),
    .io_data       (io_data),
    .fast_ptr      (fast_ptr),
    .flags         (flags),
    .err_code      (err_code),
    .done          (done),
    .irq           (irq)
);

// File: tb/sim_cam_fastread_port.sv
module sim_cam_fastread_port;

    localparam int DEPTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic              queue_empty = 1'b1;
    logic              ioreg_wr_en = 1'b0;
    logic [1:0]        ioreg_wr_sel = 2'b00;
    logic [15:0]       ioreg_wr_data = '0;
    logic              tbl_wr_en = 1'b0;
    logic [ADDR_W-1:0] tbl_wr_addr = '0;
    logic [63:0]       tbl_wr_data = '0;
    logic              flag_clr_wr = 1'b0;
    logic [15:0]       flag_clr_data = '0;
    logic              irq_en_wr = 1'b0;
    logic [15:0]       irq_en_data = '0;
    logic [63:0]       io_data;
    logic [13:0]       fast_ptr;
    logic [15:0]       flags;
    logic [15:0]       err_code;
    logic              done;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cam_fastread_port #(.DEPTH(DEPTH)) u0 (.*);

    // vector: [39:38] op, [37] queue_empty, [36:35] err (0 none, 1 FFFC, 2 FFFD),
    //         [27:14] word-0 argument, [13:0] expected pointer
    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {2'b01, 1'b1, 2'd0, 7'd0, 14'd3,      14'd3},
        {2'b10, 1'b1, 2'd0, 7'd0, 14'd0,      14'd4},
        {2'b10, 1'b1, 2'd0, 7'd0, 14'd0,      14'd5},
        {2'b10, 1'b0, 2'd1, 7'd0, 14'd0,      14'd5},
        {2'b01, 1'b0, 2'd2, 7'd0, 14'd9,      14'd5},
        {2'b01, 1'b1, 2'd0, 7'd0, 14'd15,     14'd15},
        {2'b10, 1'b1, 2'd0, 7'd0, 14'd0,      14'd0},
        {2'b10, 1'b1, 2'd0, 7'd0, 14'd0,      14'd1},
        {2'b00, 1'b1, 2'd0, 7'd0, 14'd7,      14'd1},
        {2'b11, 1'b0, 2'd0, 7'd0, 14'd8,      14'd1},
        {2'b01, 1'b1, 2'd0, 7'd0, 14'h3FFF,   14'h3FFF},
        {2'b10, 1'b1, 2'd0, 7'd0, 14'd0,      14'd0}
    };

    function automatic logic [63:0] ent(input int k);
        if (k < 0 || k >= DEPTH)
            return 64'd0;
        return {16'hA000 | 16'(k), 16'hB000 | 16'(k), 16'hC000 | 16'(k), 16'hD000 | 16'(k)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_io(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        ioreg_wr_en = 1'b1; ioreg_wr_sel = sel; ioreg_wr_data = d;
        @(negedge clk);
        ioreg_wr_en = 1'b0;
    endtask

    task automatic clr_flags(input logic [15:0] m);
        @(negedge clk);
        flag_clr_wr = 1'b1; flag_clr_data = m;
        @(negedge clk);
        flag_clr_wr = 1'b0; flag_clr_data = '0;
    endtask

    task automatic issue(input logic [1:0] op, input logic qe);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; queue_empty = qe;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; queue_empty = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [63:0] io_model;
        int          ptr_model;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ptr", 64'(fast_ptr), 64'd0);
        chk("R1 io", io_data, 64'd0);
        chk("R1 err_code", 64'(err_code), 64'd0);
        chk("R1 err flag", 64'(flags[7]), 64'd0);
        chk("R1 done/irq", {62'd0, done, irq}, 64'd0);

        // R13 preload through the table write port
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            tbl_wr_en = 1'b1; tbl_wr_addr = ADDR_W'(k); tbl_wr_data = ent(k);
        end
        @(negedge clk);
        tbl_wr_en = 1'b0;

        io_model  = 64'd0;
        ptr_model = 0;
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic        qe;
            logic [1:0]  er;
            logic [13:0] arg;
            logic [13:0] xp;
            op  = VEC[i][39:38];
            qe  = VEC[i][37];
            er  = VEC[i][36:35];
            arg = VEC[i][27:14];
            xp  = VEC[i][13:0];
            host_io(2'd0, {2'b00, arg});
            io_model[15:0] = {2'b00, arg};
            clr_flags(16'hFFFF);
            issue(op, qe);
            if (op == 2'b10 && qe) begin
                io_model = ent(ptr_model);
                chk("R4 done pulse", 64'(done), 64'd1);
                chk("R4 top word", 64'(io_data[63:48]), 64'(io_model[63:48]));
            end else begin
                chk("R7 R12 no done", 64'(done), 64'd0);
            end
            chk("R3 R5 R6 R8 R12 ptr", 64'(fast_ptr), 64'(xp));
            chk("R4 R6 R7 io data", io_data, io_model);
            chk("R7 R8 R12 err flag", 64'(flags[7]), 64'(er != 2'd0));
            if (er == 2'd1) chk("R7 code", 64'(err_code), 64'hFFFC);
            if (er == 2'd2) chk("R8 code", 64'(err_code), 64'hFFFD);
            ptr_model = int'(xp);
        end

        // R4 done lasts one cycle
        issue(2'b10, 1'b1);
        chk("R4 done high", 64'(done), 64'd1);
        @(negedge clk);
        chk("R4 done one cycle", 64'(done), 64'd0);

        // R9 queue-empty mirror
        queue_empty = 1'b0;
        #1;
        chk("R9 qe low", 64'(flags[4]), 64'd0);
        queue_empty = 1'b1;
        #1;
        chk("R9 qe high", 64'(flags[4]), 64'd1);

        // R10 write-one-to-clear behaviour
        issue(2'b10, 1'b0);
        clr_flags(16'h0000);
        chk("R10 zero write keeps", 64'(flags[7]), 64'd1);
        clr_flags(16'h0080);
        chk("R10 one write clears", 64'(flags[7]), 64'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; queue_empty = 1'b0;
        flag_clr_wr = 1'b1; flag_clr_data = 16'h0080;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; queue_empty = 1'b1;
        flag_clr_wr = 1'b0; flag_clr_data = '0;
        chk("R10 set wins", 64'(flags[7]), 64'd1);

        // R11 interrupt gating
        chk("R11 irq off", 64'(irq), 64'd0);
        @(negedge clk);
        irq_en_wr = 1'b1; irq_en_data = 16'h0080;
        @(negedge clk);
        irq_en_wr = 1'b0;
        chk("R11 irq on", 64'(irq), 64'd1);
        clr_flags(16'h0080);
        chk("R11 irq drops", 64'(irq), 64'd0);

        // R2 host write to word 2
        host_io(2'd2, 16'h1234);
        chk("R2 word2", 64'(io_data[47:32]), 64'h1234);

        // R13 rewrite one entry and read it back
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = ADDR_W'(5); tbl_wr_data = 64'h0123_4567_89AB_CDEF;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        host_io(2'd0, 16'd5);
        issue(2'b01, 1'b1);
        issue(2'b10, 1'b1);
        chk("R13 readback", io_data, 64'h0123_4567_89AB_CDEF);
        chk("R5 ptr after", 64'(fast_ptr), 64'd6);

        summary();
    end

endmodule